// File: doc/BRIEF.md
# Equalizer Tap Stream Generator for a Segmented PAM-4/NRZ Driver

This block prepares the data that feeds the weighted segments of a transmit driver with feed-forward equalization. On every cycle of the bundle clock it produces one 8-symbol bundle per driver segment. Those bundles are later serialized to the line by logic outside this block. The block pulls a 40-bit word per path, the less significant and the more significant PAM-4 bit, from upstream. It cuts each word into bundles and keeps a three-bundle window per path, so that it can form five tap streams. These streams are the same data shifted by -2 to +2 symbol slots.

For each segment there is a tap select code and a polarity bit. Each driver segment is therefore fed either a delayed or advanced copy of the data, or its complement. The analog side turns the weighted sum of the segments into a line waveform whose tap weights are set by the segment sizes. The LSB path feeds segments of relative size 3, 6, 12 and 3. The MSB path feeds segments of size 6, 12, 24 and 6.

Four operating modes are supported:
- full-speed PAM-4
- full-speed NRZ
- half-speed NRZ, where each bit is repeated over two symbol slots
- quarter-speed NRZ, where each bit is repeated over four symbol slots

In the slower modes, tap codes that fall between whole bits are redirected to the main cursor.

Top module: `tapgen_ffe`

## Requirements
- R1: `word_take_o` is high in the cycle before each edge at which the input words and `mode_i` are sampled. It is high in the first cycle after reset. It rises again after 5, 10 or 20 cycles, depending on whether the sampled word is full speed (modes 0 and 1), half speed (mode 2) or quarter speed (mode 3). It is never high in two consecutive cycles.
- R2: Word bit 0 is the earliest symbol. Bundle bit 0 is the earliest symbol of a bundle. The first bundle of a word sampled at edge E appears on the segment outputs after edge E+2. Later bundles follow one per cycle with no gap.
- R3: A segment whose effective select code is c (0 to 4) carries, in bit i of the bundle holding symbols 8t to 8t+7, the symbol with index 8t+i+c-2. Code 2 is the main cursor. Symbols before the first word after reset count as 0. Neighbour bundles supply the symbols that cross a bundle edge.
- R4: In mode 0 (full-speed PAM-4), the LSB path carries symbols from `word_lsb_i` and the MSB path carries symbols from `word_msb_i`. Each path applies its own selects.
- R5: In modes 1, 2 and 3 (NRZ), the value of `word_msb_i` has no effect. Both paths carry the `word_lsb_i` data and still select taps independently.
- R6: In mode 2 (half speed), each word bit fills two consecutive symbol slots. Codes 1 and 3 act as code 2.
- R7: In mode 3 (quarter speed), each word bit fills four consecutive symbol slots. Every code other than 4 acts as code 2.
- R8: Select codes 5, 6 and 7 act as code 2 in every mode.
- R9: A segment whose polarity bit is 1 outputs the bitwise complement of its selected stream.
- R10: `mode_i` is sampled only together with a word. All bundles cut from a word use that word's mode for repetition and for remapping the tap codes. A `mode_i` change, or any word input change, between sampling edges has no effect.
- R11: While reset is active, all segment outputs are 0 and `word_take_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bundle clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 full-speed PAM-4, 1 full-speed NRZ, 2 half-speed NRZ, 3 quarter-speed NRZ |
| word_lsb_i | input | 40 | Less significant PAM-4 bits, or the NRZ bits; bit 0 is sent first |
| word_msb_i | input | 40 | More significant PAM-4 bits, bit 0 first |
| sel_lsb_i | input | 12 | Tap code of LSB segment s in bits [3s+2:3s] |
| pol_lsb_i | input | 4 | Inversion bit of LSB segment s in bit s |
| sel_msb_i | input | 12 | Tap code of MSB segment s in bits [3s+2:3s] |
| pol_msb_i | input | 4 | Inversion bit of MSB segment s in bit s |
| word_take_o | output | 1 | Words and mode are sampled at the next edge |
| seg_lsb_o | output | 32 | Bundle of LSB segment s in bits [8s+7:8s] (sizes 3, 6, 12, 3) |
| seg_msb_o | output | 32 | Bundle of MSB segment s in bits [8s+7:8s] (sizes 6, 12, 24, 6) |

## Verification
The assertions take for granted that reset is applied before the first useful edge. They also take for granted that every bundle is cut from a single word, which keeps the repeated-symbol groups and the NRZ copy aligned within each bundle. No assumption is placed on `mode_i`, the selects or the polarity bits, which may change in any cycle. The stimulus gives each word its own mode, drives junk modes and junk words between sampling edges, and mixes word modes within one run. This shows that only sampled values matter while the boundary bundles still pick up their neighbours' symbols.

// File: rtl/tapgen_pkg.sv
package tapgen_pkg;

   typedef enum logic [1:0] {
      MODE_PAM4_FS = 2'd0,
      MODE_NRZ_FS  = 2'd1,
      MODE_NRZ_HS  = 2'd2,
      MODE_NRZ_QS  = 2'd3
   } tx_mode_e;

   // log2 of the number of symbol slots one word bit occupies
   function automatic int unsigned rep_shift(tx_mode_e m);
      case (m)
         MODE_NRZ_HS: return 1;
         MODE_NRZ_QS: return 2;
         default:     return 0;
      endcase
   endfunction

   function automatic logic is_nrz(tx_mode_e m);
      return m != MODE_PAM4_FS;
   endfunction

endpackage

// File: rtl/tapgen_gearbox.sv
module tapgen_gearbox
   import tapgen_pkg::*;
#(
   parameter int unsigned WORD_W   = 40,
   parameter int unsigned BUNDLE_W = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  tx_mode_e            mode_i,
   input  logic [WORD_W-1:0]   word_lsb_i,
   input  logic [WORD_W-1:0]   word_msb_i,
   output logic                word_take_o,
   output logic [BUNDLE_W-1:0] bnd_lsb_o,
   output logic [BUNDLE_W-1:0] bnd_msb_o,
   output tx_mode_e            bnd_mode_o,
   output tx_mode_e            mode_act_o
);

   localparam int unsigned BPW    = WORD_W / BUNDLE_W;
   localparam int unsigned PH_CNT = 4 * BPW;
   localparam int unsigned PH_W   = $clog2(PH_CNT);
   localparam int unsigned IDX_W  = $clog2(WORD_W);

   logic [PH_W-1:0]   ph_q;
   logic [WORD_W-1:0] wl_q, wm_q;
   tx_mode_e          mode_q;

   logic              take;
   tx_mode_e          mode_eff;
   logic [WORD_W-1:0] src_l, src_m;
   logic [PH_W-1:0]   last_ph;
   int unsigned       sh;

   always_comb begin
      take     = (ph_q == '0);
      mode_eff = take ? mode_i : mode_q;
      src_l    = take ? word_lsb_i : wl_q;
      if (take) src_m = is_nrz(mode_i) ? word_lsb_i : word_msb_i;
      else      src_m = wm_q;
      sh       = rep_shift(mode_eff);
      last_ph  = PH_W'((BPW << sh) - 1);
   end

   // one output bit per bundle position; the word bit index depends on repetition
   for (genvar j = 0; j < BUNDLE_W; j++) begin : g_bit
      logic [IDX_W-1:0] idx;
      always_comb begin
         idx          = IDX_W'(((int'(ph_q) * BUNDLE_W) + j) >> sh);
         bnd_lsb_o[j] = src_l[idx];
         bnd_msb_o[j] = src_m[idx];
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ph_q   <= '0;
         wl_q   <= '0;
         wm_q   <= '0;
         mode_q <= MODE_PAM4_FS;
      end else begin
         ph_q <= (ph_q == last_ph) ? '0 : ph_q + 1'b1;
         if (take) begin
            wl_q   <= word_lsb_i;
            wm_q   <= src_m;
            mode_q <= mode_i;
         end
      end
   end

   assign word_take_o = take;
   assign bnd_mode_o  = mode_eff;
   assign mode_act_o  = mode_q;

endmodule

// File: rtl/tapgen_tapline.sv
module tapgen_tapline
   import tapgen_pkg::*;
#(
   parameter int unsigned BUNDLE_W = 8,
   parameter int unsigned TAP_SIDE = 2
) (
   input  logic                                   clk,
   input  logic                                   rst,
   input  logic [BUNDLE_W-1:0]                    bnd_i,
   input  tx_mode_e                               mode_i,
   output logic [(2*TAP_SIDE+1)*BUNDLE_W-1:0]     taps_o,
   output tx_mode_e                               mode_o
);

   localparam int unsigned NUM_TAP = 2 * TAP_SIDE + 1;
   localparam int unsigned WIN_W   = BUNDLE_W + 2 * TAP_SIDE;

   logic [BUNDLE_W-1:0] nxt_q, cur_q, prv_q;
   tx_mode_e            nxt_mode_q, cur_mode_q;
   logic [WIN_W-1:0]    win;

   always_ff @(posedge clk) begin
      if (rst) begin
         nxt_q      <= '0;
         cur_q      <= '0;
         prv_q      <= '0;
         nxt_mode_q <= MODE_PAM4_FS;
         cur_mode_q <= MODE_PAM4_FS;
      end else begin
         nxt_q      <= bnd_i;
         cur_q      <= nxt_q;
         prv_q      <= cur_q;
         nxt_mode_q <= mode_i;
         cur_mode_q <= nxt_mode_q;
      end
   end

   // window: tail of the older bundle, the current bundle, head of the newer one
   assign win = {nxt_q[TAP_SIDE-1:0], cur_q, prv_q[BUNDLE_W-1 -: TAP_SIDE]};

   for (genvar c = 0; c < NUM_TAP; c++) begin : g_tap
      assign taps_o[c*BUNDLE_W +: BUNDLE_W] = win[c +: BUNDLE_W];
   end

   assign mode_o = cur_mode_q;

endmodule

// File: rtl/tapgen_segmux.sv
module tapgen_segmux
   import tapgen_pkg::*;
#(
   parameter int unsigned BUNDLE_W = 8,
   parameter int unsigned TAP_SIDE = 2,
   parameter int unsigned NUM_SEG  = 4
) (
   input  logic                                       clk,
   input  logic                                       rst,
   input  logic [(2*TAP_SIDE+1)*BUNDLE_W-1:0]         taps_i,
   input  tx_mode_e                                   mode_i,
   input  logic [NUM_SEG*$clog2(2*TAP_SIDE+1)-1:0]    sel_i,
   input  logic [NUM_SEG-1:0]                         pol_i,
   output logic [NUM_SEG*BUNDLE_W-1:0]                seg_o
);

   localparam int unsigned NUM_TAP = 2 * TAP_SIDE + 1;
   localparam int unsigned SEL_W   = $clog2(NUM_TAP);
   localparam logic [SEL_W-1:0] CENTER = SEL_W'(TAP_SIDE);
   localparam logic [SEL_W-1:0] LAST   = SEL_W'(NUM_TAP - 1);

   // codes between whole bits in the oversampled modes fall back to the main cursor
   function automatic logic [SEL_W-1:0] eff_sel(tx_mode_e m, logic [SEL_W-1:0] s);
      logic [SEL_W-1:0] r;
      r = (int'(s) < NUM_TAP) ? s : CENTER;
      case (m)
         MODE_NRZ_HS: if (r != '0 && r != LAST) r = CENTER;
         MODE_NRZ_QS: if (r != LAST) r = CENTER;
         default: ;
      endcase
      return r;
   endfunction

   for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
      logic [SEL_W-1:0]    code;
      logic [BUNDLE_W-1:0] pick;
      always_comb begin
         code = eff_sel(mode_i, sel_i[s*SEL_W +: SEL_W]);
         pick = taps_i[code*BUNDLE_W +: BUNDLE_W];
      end
      always_ff @(posedge clk) begin
         if (rst) seg_o[s*BUNDLE_W +: BUNDLE_W] <= '0;
         else     seg_o[s*BUNDLE_W +: BUNDLE_W] <= pol_i[s] ? ~pick : pick;
      end
   end

endmodule

// File: rtl/tapgen_ffe.sv
module tapgen_ffe
   import tapgen_pkg::*;
#(
   parameter int unsigned WORD_W   = 40,
   parameter int unsigned BUNDLE_W = 8,
   parameter int unsigned TAP_SIDE = 2,
   parameter int unsigned NUM_SEG  = 4
) (
   input  logic                                    clk,
   input  logic                                    rst,
   input  logic [1:0]                              mode_i,
   input  logic [WORD_W-1:0]                       word_lsb_i,
   input  logic [WORD_W-1:0]                       word_msb_i,
   input  logic [NUM_SEG*$clog2(2*TAP_SIDE+1)-1:0] sel_lsb_i,
   input  logic [NUM_SEG-1:0]                      pol_lsb_i,
   input  logic [NUM_SEG*$clog2(2*TAP_SIDE+1)-1:0] sel_msb_i,
   input  logic [NUM_SEG-1:0]                      pol_msb_i,
   output logic                                    word_take_o,
   output logic [NUM_SEG*BUNDLE_W-1:0]             seg_lsb_o,
   output logic [NUM_SEG*BUNDLE_W-1:0]             seg_msb_o
);

   localparam int unsigned NUM_TAP = 2 * TAP_SIDE + 1;
   localparam int unsigned TAPS_W  = NUM_TAP * BUNDLE_W;

   if (WORD_W % BUNDLE_W != 0) begin : g_bad_word
      $error("word width must be a whole number of bundles");
   end
   if (BUNDLE_W < TAP_SIDE || TAP_SIDE == 0) begin : g_bad_side
      $error("tap reach must be nonzero and fit within one bundle");
   end

   logic [BUNDLE_W-1:0] bnd_lsb, bnd_msb;
   tx_mode_e            bnd_mode, mode_act, lsb_cur_mode, msb_cur_mode;
   logic [TAPS_W-1:0]   lsb_taps, msb_taps;

   tapgen_gearbox #(.WORD_W(WORD_W), .BUNDLE_W(BUNDLE_W)) u_gear (
      .clk(clk), .rst(rst), .mode_i(tx_mode_e'(mode_i)),
      .word_lsb_i(word_lsb_i), .word_msb_i(word_msb_i),
      .word_take_o(word_take_o), .bnd_lsb_o(bnd_lsb), .bnd_msb_o(bnd_msb),
      .bnd_mode_o(bnd_mode), .mode_act_o(mode_act)
   );

   tapgen_tapline #(.BUNDLE_W(BUNDLE_W), .TAP_SIDE(TAP_SIDE)) u_line_lsb (
      .clk(clk), .rst(rst), .bnd_i(bnd_lsb), .mode_i(bnd_mode),
      .taps_o(lsb_taps), .mode_o(lsb_cur_mode)
   );

   tapgen_tapline #(.BUNDLE_W(BUNDLE_W), .TAP_SIDE(TAP_SIDE)) u_line_msb (
      .clk(clk), .rst(rst), .bnd_i(bnd_msb), .mode_i(bnd_mode),
      .taps_o(msb_taps), .mode_o(msb_cur_mode)
   );

   tapgen_segmux #(.BUNDLE_W(BUNDLE_W), .TAP_SIDE(TAP_SIDE), .NUM_SEG(NUM_SEG)) u_mux_lsb (
      .clk(clk), .rst(rst), .taps_i(lsb_taps), .mode_i(lsb_cur_mode),
      .sel_i(sel_lsb_i), .pol_i(pol_lsb_i), .seg_o(seg_lsb_o)
   );

   tapgen_segmux #(.BUNDLE_W(BUNDLE_W), .TAP_SIDE(TAP_SIDE), .NUM_SEG(NUM_SEG)) u_mux_msb (
      .clk(clk), .rst(rst), .taps_i(msb_taps), .mode_i(msb_cur_mode),
      .sel_i(sel_msb_i), .pol_i(pol_msb_i), .seg_o(seg_msb_o)
   );

endmodule

// File: rtl/tapgen_ffe_chk.sv
module tapgen_ffe_chk
   import tapgen_pkg::*;
#(
   parameter int unsigned BUNDLE_W = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                word_take,
   input tx_mode_e            mode_act,
   input tx_mode_e            cur_mode,
   input logic [BUNDLE_W-1:0] c0_lsb,
   input logic [BUNDLE_W-1:0] c0_msb
);

   function automatic logic [BUNDLE_W-1:0] grp_mask(int unsigned grp);
      logic [BUNDLE_W-1:0] m;
      for (int j = 0; j < BUNDLE_W; j++) m[j] = ((j % grp) != (grp - 1));
      return m;
   endfunction

   localparam logic [BUNDLE_W-1:0] PAIR_M = grp_mask(2);
   localparam logic [BUNDLE_W-1:0] QUAD_M = grp_mask(4);

   // R1
   take_gap_chk: assert property (@(posedge clk) disable iff (rst)
      word_take |=> !word_take);

   // R10
   mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(word_take) |-> $stable(mode_act));

   // R5
   nrz_copy_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_mode != MODE_PAM4_FS) |-> (c0_lsb == c0_msb));

   // R6
   hs_pair_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_mode == MODE_NRZ_HS) |-> (((c0_lsb ^ (c0_lsb >> 1)) & PAIR_M) == '0));

   // R7
   qs_quad_chk: assert property (@(posedge clk) disable iff (rst)
      (cur_mode == MODE_NRZ_QS) |-> (((c0_lsb ^ (c0_lsb >> 1)) & QUAD_M) == '0));

endmodule

bind tapgen_ffe tapgen_ffe_chk #(.BUNDLE_W(BUNDLE_W)) u_chk (
   .clk(clk),
   .rst(rst),
   .word_take(word_take_o),
   .mode_act(mode_act),
   .cur_mode(lsb_cur_mode),
   .c0_lsb(lsb_taps[TAP_SIDE*BUNDLE_W +: BUNDLE_W]),
   .c0_msb(msb_taps[TAP_SIDE*BUNDLE_W +: BUNDLE_W])
);

// File: tb/tapgen_ffe_tb.sv
module tapgen_ffe_tb;

   localparam int NW = 4;
   localparam int NC = 7;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [1:0]  mode_i = '0;
   logic [39:0] wli = '0, wmi = '0;
   logic [11:0] sl = '0, sm = '0;
   logic [3:0]  pl = '0, pm = '0;
   logic        take;
   logic [31:0] segl, segm;

   always #4 clk = ~clk;

   tapgen_ffe u_dut (
      .clk(clk), .rst(rst), .mode_i(mode_i),
      .word_lsb_i(wli), .word_msb_i(wmi),
      .sel_lsb_i(sl), .pol_lsb_i(pl), .sel_msb_i(sm), .pol_msb_i(pm),
      .word_take_o(take), .seg_lsb_o(segl), .seg_msb_o(segm)
   );

   // per case: word modes (word k in bits [2k+1:2k]), LSB selects/polarity, MSB selects/polarity
   typedef struct packed {
      logic [7:0]  modes;
      logic [11:0] sel_l;
      logic [3:0]  pol_l;
      logic [11:0] sel_m;
      logic [3:0]  pol_m;
   } case_t;

   localparam case_t CASES [NC] = '{
      '{8'b00_00_00_00, 12'o3210, 4'b0000, 12'o4321, 4'b1010},
      '{8'b01_01_01_01, 12'o0124, 4'b0001, 12'o2343, 4'b0000},
      '{8'b10_10_10_10, 12'o0123, 4'b0100, 12'o4210, 4'b1001},
      '{8'b11_11_11_11, 12'o4012, 4'b0000, 12'o3421, 4'b1111},
      '{8'b00_00_00_00, 12'o5672, 4'b0011, 12'o7564, 4'b0000},
      '{8'b10_01_11_00, 12'o0123, 4'b0110, 12'o4012, 4'b0001},
      '{8'b11_00_10_00, 12'o4444, 4'b0101, 12'o0000, 4'b0000}
   };
   localparam string CASE_REQ [NC] = '{
      "R2/R3/R4/R9", "R3/R5/R9", "R6/R9", "R7/R9", "R8/R9", "R10/R5/R7", "R10/R6/R4"
   };

   int checks = 0;
   int fails  = 0;

   logic [39:0] wl [NW];
   logic [39:0] wm [NW];
   logic [1:0]  wmode [NW];
   int          start [NW+1];

   function automatic logic [39:0] gen(int c, int k, int p);
      logic [63:0] x;
      x = 64'(c * 131 + k * 17 + p * 7 + 1) * 64'h9E37_79B9_7F4A_7C15;
      return x[63:24];
   endfunction

   function automatic int rsh(logic [1:0] m);
      return (m == 2'd2) ? 1 : (m == 2'd3) ? 2 : 0;
   endfunction

   function automatic int word_of(int n);
      int k = 0;
      for (int q = 1; q < NW; q++) if (n >= start[q]) k = q;
      return k;
   endfunction

   function automatic logic sym(int p, int n);
      int k, b;
      if (n < 0) return 1'b0;
      k = word_of(n);
      b = (n - start[k]) >> rsh(wmode[k]);
      if (p == 0 || wmode[k] != 2'd0) return wl[k][b];
      return wm[k][b];
   endfunction

   function automatic int remap(logic [1:0] m, int s);
      int r;
      r = (s > 4) ? 2 : s;
      if (m == 2'd2 && r != 0 && r != 4) r = 2;
      if (m == 2'd3 && r != 4) r = 2;
      return r;
   endfunction

   function automatic logic [31:0] expect_bnd(int p, int t, logic [11:0] sel, logic [3:0] pol);
      logic [31:0] v;
      logic [1:0]  m;
      m = wmode[word_of(8 * t)];
      for (int s = 0; s < 4; s++) begin
         int c;
         c = remap(m, int'(sel[3*s +: 3]));
         for (int i = 0; i < 8; i++) v[8*s+i] = sym(p, 8*t + i + c - 2) ^ pol[s];
      end
      return v;
   endfunction

   task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp, int t);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s at %0d: got %h expected %h", req, what, t, got, exp);
      end
   endtask

   task automatic run_case(int c);
      int nb_total, k;
      sl = CASES[c].sel_l; pl = CASES[c].pol_l;
      sm = CASES[c].sel_m; pm = CASES[c].pol_m;
      start[0] = 0;
      for (int q = 0; q < NW; q++) begin
         wl[q]       = gen(c, q, 0);
         wm[q]       = gen(c, q, 1);
         wmode[q]    = CASES[c].modes[2*q +: 2];
         start[q+1]  = start[q] + (40 << rsh(wmode[q]));
      end
      nb_total = start[NW-1] / 8;
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R11: reset state seen before the first edge with reset low
      chk("R11", "seg_lsb reset", segl, 32'h0, c);
      chk("R11", "seg_msb reset", segm, 32'h0, c);
      chk("R11", "take reset", {31'h0, take}, 32'h1, c);
      k = 0;
      for (int cyc = 0; cyc <= nb_total + 2; cyc++) begin
         if (cyc >= 3) begin
            chk(CASE_REQ[c], "lsb bundle", segl, expect_bnd(0, cyc - 3, sl, pl), cyc - 3);
            chk(CASE_REQ[c], "msb bundle", segm, expect_bnd(1, cyc - 3, sm, pm), cyc - 3);
         end
         if (cyc < nb_total) begin
            logic exp_take;
            exp_take = 1'b0;
            for (int q = 0; q < NW - 1; q++) if (start[q] / 8 == cyc) exp_take = 1'b1;
            // R1: take pulses exactly at word boundaries
            chk("R1", "word_take", {31'h0, take}, {31'h0, exp_take}, cyc);
         end
         if (take) begin
            if (k < NW) begin
               wli = wl[k]; wmi = wm[k]; mode_i = wmode[k];
            end else begin
               wli = '0; wmi = '0; mode_i = 2'd0;
            end
            k++;
         end else begin
            // R10: junk between sampling edges must have no effect
            wli    = gen(c, cyc + 50, 0);
            wmi    = gen(c, cyc + 90, 1);
            mode_i = 2'(cyc);
         end
         @(negedge clk);
      end
   endtask

   initial begin
      for (int c = 0; c < NC; c++) run_case(c);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule